// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic read-modify-write operation for a processor core. The core hands it an instruction word, a base address and a source operand. The block first asks an external translator for a read-write mapping of the base address. It then uses the translated address on a simple memory port, in this order: it announces the write address, reads the current value and writes back the combined value. The value that was in memory before the operation is returned for the destination register.

The arithmetic covers exchange, addition, three bitwise operations, and signed and unsigned minimum and maximum, on 32-bit or 64-bit data. Any step may report a fault. A fault ends the sequence at once and reports a cause code and the address that applies to that step. The translator and the memory are both request/response handshakes: a request is held until the matching response arrives, so either side may insert wait cycles.

Top module: `amo_seq`

## Requirements
- R1: The instruction is decoded from bits [6:0] = 0b0101111, bits [14:12] (0b010 = 32-bit, 0b011 = 64-bit) and bits [31:27] (00001 exchange, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max). Any other encoding ends in a fault with cause 0 and the base address, and the block makes no request on the translator or the memory port.
- R2: The steps run in a strict order. First a translation request carries the base address with permission code 2'b11 (read and write). Then memory commands follow at the translated address: announce (1), read (2) and write (3). The translated address stays the same across the three memory commands.
- R3: Exchange writes the source operand unchanged. Add, xor, and and or write the source operand combined with the value read.
- R4: Signed min and max compare as two's complement values. Unsigned min and max compare as unsigned values.
- R5: A 32-bit operation uses access size 4, computes on the low 32 bits of both operands and writes the result with the upper 32 bits zero. A 64-bit operation uses access size 8 and the full width.
- R6: The destination value is the value read, not the result. For 32-bit operations it is sign-extended by default. It changes only together with the done pulse, which follows a successful write.
- R7: A failed translation ends the sequence with cause 1 and reports the untranslated base address.
- R8: A fault on the announce, read or write ends the sequence with cause 2, 3 or 4 and reports the translated address. No later step is issued and the destination value keeps its previous contents.
- R9: A request is accepted only when the block is idle. Requests presented while busy have no effect. Busy is high from the cycle after acceptance until the done or fault pulse, and each of these pulses lasts one cycle.
- R10: After reset the block is idle with busy, done, fault and both request outputs low, and the destination value zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an operation (taken only when idle) |
| req_insn | input | 32 | Instruction word to decode |
| req_base | input | XLEN | Untranslated base address |
| req_src | input | XLEN | Source operand |
| busy | output | 1 | Sequence in progress |
| xl_req | output | 1 | Translation request, held until response |
| xl_perm | output | 2 | Requested permission (read, write) |
| xl_vaddr | output | XLEN | Address to translate |
| xl_rsp_valid | input | 1 | Translation response |
| xl_rsp_fault | input | 1 | Translation failed |
| xl_paddr | input | XLEN | Translated address |
| mem_req | output | 1 | Memory request, held until response |
| mem_cmd | output | 2 | 1 announce, 2 read, 3 write |
| mem_addr | output | XLEN | Translated address |
| mem_size | output | 4 | Access size in bytes (4 or 8) |
| mem_wdata | output | XLEN | Write data |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_fault | input | 1 | Memory access faulted |
| mem_rdata | input | XLEN | Read data |
| done | output | 1 | One-cycle completion pulse |
| rd_value | output | XLEN | Destination register value |
| fault | output | 1 | One-cycle fault pulse |
| fault_cause | output | 3 | 0 illegal, 1 translate, 2 announce, 3 read, 4 write |
| fault_addr | output | XLEN | Address associated with the fault |

## Verification
The hardest case to reach from the ports is a fault on the final write. At that point the block has already read memory and computed a result, yet it must still leave the destination value unchanged and emit no done pulse. The bench answers each handshake itself, cycle by cycle, and can inject a fault at any chosen step, so it can fail exactly the write after a good read. It can also stretch each step with wait cycles, and it can present a competing request while busy, which shows that the held request and the step order survive both.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [3:0] {
        OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
        OP_MIN, OP_MAX, OP_MINU, OP_MAXU
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_XLATE, ST_EA, ST_READ, ST_WRITE, ST_DONE, ST_FAULT
    } amo_state_e;

    typedef enum logic [2:0] {
        CAUSE_ILLEGAL = 3'd0,
        CAUSE_XLATE   = 3'd1,
        CAUSE_EA      = 3'd2,
        CAUSE_READ    = 3'd3,
        CAUSE_WRITE   = 3'd4
    } amo_cause_e;

    typedef enum logic [1:0] {
        MCMD_NONE  = 2'd0,
        MCMD_EA    = 2'd1,
        MCMD_READ  = 2'd2,
        MCMD_WRITE = 2'd3
    } amo_mcmd_e;

    localparam logic [6:0] AMO_OPCODE  = 7'b0101111;
    localparam logic [2:0] AMO_F3_WORD = 3'b010;
    localparam logic [2:0] AMO_F3_DBL  = 3'b011;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [31:0] insn,
    output amo_op_e     op,
    output logic        dword,
    output logic        legal
);
    logic [4:0] grp;
    logic [2:0] wsel;
    logic       op_ok;
    logic       w_ok;

    assign grp  = insn[31:27];
    assign wsel = insn[14:12];

    always_comb begin
        op_ok = 1'b1;
        unique case (grp)
            5'b00001: op = OP_SWAP;
            5'b00000: op = OP_ADD;
            5'b00100: op = OP_XOR;
            5'b01100: op = OP_AND;
            5'b01000: op = OP_OR;
            5'b10000: op = OP_MIN;
            5'b10100: op = OP_MAX;
            5'b11000: op = OP_MINU;
            5'b11100: op = OP_MAXU;
            default: begin
                op    = OP_SWAP;
                op_ok = 1'b0;
            end
        endcase
    end

    always_comb begin
        w_ok  = (wsel == AMO_F3_WORD) || (wsel == AMO_F3_DBL);
        dword = (wsel == AMO_F3_DBL);
        legal = op_ok && w_ok && (insn[6:0] == AMO_OPCODE);
    end

endmodule

// File: rtl/amo_lane.sv
module amo_lane
    import amo_pkg::*;
#(
    parameter int W = 32
) (
    input  amo_op_e      op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] mem,
    output logic [W-1:0] y
);
    logic s_lt;
    logic u_lt;

    assign s_lt = $signed(src) < $signed(mem);
    assign u_lt = src < mem;

    always_comb begin
        unique case (op)
            OP_SWAP: y = src;
            OP_ADD:  y = src + mem;
            OP_XOR:  y = src ^ mem;
            OP_AND:  y = src & mem;
            OP_OR:   y = src | mem;
            OP_MIN:  y = s_lt ? src : mem;
            OP_MAX:  y = s_lt ? mem : src;
            OP_MINU: y = u_lt ? src : mem;
            OP_MAXU: y = u_lt ? mem : src;
            default: y = src;
        endcase
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_op_e         op,
    input  logic            dword,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] mem,
    output logic [XLEN-1:0] y
);
    localparam int NLANE = 2;

    logic [XLEN-1:0] lane_y [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        localparam int LW = (g == 0) ? 32 : XLEN;
        logic [LW-1:0] ly;
        amo_lane #(.W(LW)) u_lane (
            .op  (op),
            .src (src[LW-1:0]),
            .mem (mem[LW-1:0]),
            .y   (ly)
        );
        assign lane_y[g] = XLEN'(ly);
    end

    assign y = dword ? lane_y[1] : lane_y[0];

endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter bit WORD_SIGN_EXT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [31:0]     req_insn,
    input  logic [XLEN-1:0] req_base,
    input  logic [XLEN-1:0] req_src,
    output logic            busy,
    output logic            xl_req,
    output logic [1:0]      xl_perm,
    output logic [XLEN-1:0] xl_vaddr,
    input  logic            xl_rsp_valid,
    input  logic            xl_rsp_fault,
    input  logic [XLEN-1:0] xl_paddr,
    output logic            mem_req,
    output logic [1:0]      mem_cmd,
    output logic [XLEN-1:0] mem_addr,
    output logic [3:0]      mem_size,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_rsp_valid,
    input  logic            mem_rsp_fault,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            done,
    output logic [XLEN-1:0] rd_value,
    output logic            fault,
    output logic [2:0]      fault_cause,
    output logic [XLEN-1:0] fault_addr
);
    localparam int HI = XLEN - 32;

    typedef struct packed {
        amo_state_e      st;
        amo_op_e         op;
        logic            dword;
        logic [XLEN-1:0] vaddr;
        logic [XLEN-1:0] paddr;
        logic [XLEN-1:0] src;
        logic [XLEN-1:0] loaded;
        logic [XLEN-1:0] old;
        logic [XLEN-1:0] faddr;
        amo_cause_e      cause;
    } seq_regs_t;

    seq_regs_t q, d;

    amo_op_e         dec_op;
    logic            dec_dword;
    logic            dec_legal;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] rd_ext;

    amo_decode u_dec (
        .insn  (req_insn),
        .op    (dec_op),
        .dword (dec_dword),
        .legal (dec_legal)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op    (q.op),
        .dword (q.dword),
        .src   (q.src),
        .mem   (q.loaded),
        .y     (alu_y)
    );

    // Captured read data, widened for 32-bit operations.
    assign rd_ext = q.dword ? mem_rdata
                  : {{HI{WORD_SIGN_EXT & mem_rdata[31]}}, mem_rdata[31:0]};

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.vaddr = req_base;
                    d.src   = req_src;
                    d.op    = dec_op;
                    d.dword = dec_dword;
                    if (dec_legal) begin
                        d.st = ST_XLATE;
                    end else begin
                        d.st    = ST_FAULT;
                        d.cause = CAUSE_ILLEGAL;
                        d.faddr = req_base;
                    end
                end
            end
            ST_XLATE: begin
                if (xl_rsp_valid) begin
                    if (xl_rsp_fault) begin
                        d.st    = ST_FAULT;
                        d.cause = CAUSE_XLATE;
                        d.faddr = q.vaddr;
                    end else begin
                        d.paddr = xl_paddr;
                        d.st    = ST_EA;
                    end
                end
            end
            ST_EA: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        d.st    = ST_FAULT;
                        d.cause = CAUSE_EA;
                        d.faddr = q.paddr;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        d.st    = ST_FAULT;
                        d.cause = CAUSE_READ;
                        d.faddr = q.paddr;
                    end else begin
                        d.loaded = rd_ext;
                        d.st     = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_fault) begin
                        d.st    = ST_FAULT;
                        d.cause = CAUSE_WRITE;
                        d.faddr = q.paddr;
                    end else begin
                        d.old = q.loaded;
                        d.st  = ST_DONE;
                    end
                end
            end
            ST_DONE:  d.st = ST_IDLE;
            ST_FAULT: d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_SWAP, cause: CAUSE_ILLEGAL, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy        = (q.st == ST_XLATE) || (q.st == ST_EA) ||
                      (q.st == ST_READ)  || (q.st == ST_WRITE);
        xl_req      = (q.st == ST_XLATE);
        xl_perm     = 2'b11;
        xl_vaddr    = q.vaddr;
        mem_req     = (q.st == ST_EA) || (q.st == ST_READ) || (q.st == ST_WRITE);
        unique case (q.st)
            ST_EA:    mem_cmd = MCMD_EA;
            ST_READ:  mem_cmd = MCMD_READ;
            ST_WRITE: mem_cmd = MCMD_WRITE;
            default:  mem_cmd = MCMD_NONE;
        endcase
        mem_addr    = q.paddr;
        mem_size    = q.dword ? 4'd8 : 4'd4;
        mem_wdata   = (q.st == ST_WRITE) ? alu_y : '0;
        done        = (q.st == ST_DONE);
        rd_value    = q.old;
        fault       = (q.st == ST_FAULT);
        fault_cause = q.cause;
        fault_addr  = q.faddr;
    end

    // Busy and the two end pulses never overlap.
    assert_end_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, busy}));

    // Completion only directly after an accepted write.
    assert_done_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_cmd == MCMD_WRITE && mem_rsp_valid && !mem_rsp_fault));

    // A translation-cause fault follows a failed translation response.
    assert_xlate_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && fault_cause == CAUSE_XLATE) |-> $past(xl_req && xl_rsp_valid && xl_rsp_fault));

    // Translator and memory port are never requested together.
    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req && mem_req));

    // The translated address holds across consecutive memory steps.
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    // Once a memory step starts, no new translation is requested before the end pulse.
    assert_no_retranslate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_req) |-> !xl_req);

endmodule

// File: tb/sim_amo_seq.sv
module sim_amo_seq;
    localparam int XLEN = 64;
    localparam logic [63:0] XOFF = 64'h0000_00F0_0000_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [31:0]     req_insn = '0;
    logic [XLEN-1:0] req_base = '0;
    logic [XLEN-1:0] req_src = '0;
    logic            busy;
    logic            xl_req;
    logic [1:0]      xl_perm;
    logic [XLEN-1:0] xl_vaddr;
    logic            xl_rsp_valid = 1'b0;
    logic            xl_rsp_fault = 1'b0;
    logic [XLEN-1:0] xl_paddr = '0;
    logic            mem_req;
    logic [1:0]      mem_cmd;
    logic [XLEN-1:0] mem_addr;
    logic [3:0]      mem_size;
    logic [XLEN-1:0] mem_wdata;
    logic            mem_rsp_valid = 1'b0;
    logic            mem_rsp_fault = 1'b0;
    logic [XLEN-1:0] mem_rdata = '0;
    logic            done;
    logic [XLEN-1:0] rd_value;
    logic            fault;
    logic [2:0]      fault_cause;
    logic [XLEN-1:0] fault_addr;

    always #2 clk = ~clk;

    amo_seq #(.XLEN(XLEN)) u0 (.*);

    int tests = 0;
    int fails = 0;

    // Results captured by run_amo
    bit          g_done, g_fault, g_order_ok, g_pulse_ok, g_busy_ok, g_any_port;
    logic [2:0]  g_cause;
    logic [63:0] g_faddr, g_old, g_wdata, g_vaddr;
    logic [3:0]  g_size;
    logic [1:0]  g_perm;
    int          g_steps;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] f5, input logic [2:0] f3);
        return {f5, 2'b11, 5'd7, 5'd9, f3, 5'd5, 7'b0101111};
    endfunction

    function automatic logic [63:0] ref_wr(input logic [4:0] f5, input bit dw,
                                           input logic [63:0] s, input logic [63:0] m);
        logic [63:0] r;
        logic [31:0] a, b, r32;
        a = s[31:0];
        b = m[31:0];
        case (f5)
            5'b00001: begin r = s;     r32 = a;     end
            5'b00000: begin r = s + m; r32 = a + b; end
            5'b00100: begin r = s ^ m; r32 = a ^ b; end
            5'b01100: begin r = s & m; r32 = a & b; end
            5'b01000: begin r = s | m; r32 = a | b; end
            5'b10000: begin r = ($signed(s) < $signed(m)) ? s : m; r32 = ($signed(a) < $signed(b)) ? a : b; end
            5'b10100: begin r = ($signed(s) > $signed(m)) ? s : m; r32 = ($signed(a) > $signed(b)) ? a : b; end
            5'b11000: begin r = (s < m) ? s : m; r32 = (a < b) ? a : b; end
            default:  begin r = (s > m) ? s : m; r32 = (a > b) ? a : b; end
        endcase
        return dw ? r : {32'h0, r32};
    endfunction

    function automatic logic [63:0] ref_old(input bit dw, input logic [63:0] m);
        return dw ? m : {{32{m[31]}}, m[31:0]};
    endfunction

    // Drives one request and answers the handshakes. fstep: -1 none, 0 translate,
    // 1 announce, 2 read, 3 write. wcyc: wait cycles before each response.
    task automatic run_amo(input logic [31:0] insn, input logic [63:0] base, input logic [63:0] src,
                           input logic [63:0] memv, input int fstep, input int wcyc, input bit poke);
        int nxt = 0;
        int wc = 0;
        g_done = 0; g_fault = 0; g_order_ok = 1; g_busy_ok = 1; g_any_port = 0;
        g_steps = 0; g_wdata = '0; g_size = '0; g_perm = '0; g_vaddr = '0;
        @(negedge clk);
        req_valid = 1'b1; req_insn = insn; req_base = base; req_src = src;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            xl_rsp_valid = 0; xl_rsp_fault = 0; xl_paddr = '0;
            mem_rsp_valid = 0; mem_rsp_fault = 0; mem_rdata = '0;
            if (poke && cyc == 1) begin
                req_valid = 1'b1; req_insn = mk(5'b00000, 3'b011);
                req_base = 64'h5555; req_src = 64'h1;
            end else begin
                req_valid = 1'b0;
            end
            if (done || fault) begin
                g_done = done; g_fault = fault; g_cause = fault_cause;
                g_faddr = fault_addr; g_old = rd_value;
                break;
            end
            if ((xl_req || mem_req) && !busy) g_busy_ok = 0;
            if (xl_req) begin
                g_any_port = 1;
                if (nxt != 0) g_order_ok = 0;
                g_vaddr = xl_vaddr; g_perm = xl_perm;
                if (wc < wcyc) wc++;
                else begin
                    wc = 0; nxt = 1; g_steps++;
                    xl_rsp_valid = 1; xl_rsp_fault = (fstep == 0); xl_paddr = base ^ XOFF;
                end
            end
            if (mem_req) begin
                g_any_port = 1;
                if (int'(mem_cmd) != nxt || mem_addr != (base ^ XOFF)) g_order_ok = 0;
                if (wc < wcyc) wc++;
                else begin
                    wc = 0; g_steps++;
                    mem_rsp_valid = 1; mem_rsp_fault = (fstep == nxt);
                    if (mem_cmd == 2'd2) mem_rdata = memv;
                    if (mem_cmd == 2'd3) begin g_wdata = mem_wdata; g_size = mem_size; end
                    nxt++;
                end
            end
            @(negedge clk);
        end
        xl_rsp_valid = 0; xl_rsp_fault = 0; mem_rsp_valid = 0; mem_rsp_fault = 0;
        req_valid = 1'b0;
        @(negedge clk);
        g_pulse_ok = !done && !fault && !busy && !xl_req && !mem_req;
    endtask

    task automatic t_reset;
        chk(!busy && !done && !fault && !xl_req && !mem_req, "R10 idle outputs",
            {59'b0, busy, done, fault, xl_req, mem_req}, 64'h0);
        chk(rd_value == 64'h0, "R10 rd_value", rd_value, 64'h0);
    endtask

    task automatic one_op(input logic [4:0] f5, input bit dw, input logic [63:0] s,
                          input logic [63:0] m, input string tag);
        logic [63:0] base;
        base = 64'h0000_0000_8000_1000 + {59'b0, f5};
        run_amo(mk(f5, dw ? 3'b011 : 3'b010), base, s, m, -1, 0, 0);
        chk(g_done && !g_fault, {tag, " done"}, {63'b0, g_done}, 64'h1);
        chk(g_wdata == ref_wr(f5, dw, s, m), {tag, " write data"}, g_wdata, ref_wr(f5, dw, s, m));
        chk(g_old == ref_old(dw, m), {tag, " R6 old value"}, g_old, ref_old(dw, m));
        chk(g_size == (dw ? 4'd8 : 4'd4), {tag, " R5 size"}, {60'b0, g_size}, dw ? 64'd8 : 64'd4);
        chk(g_order_ok && g_steps == 4 && g_pulse_ok, {tag, " R2 order/R9 pulse"},
            {63'b0, g_order_ok}, 64'h1);
    endtask

    task automatic t_ops_double;
        logic [4:0] ops [9] = '{5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                                5'b10000, 5'b10100, 5'b11000, 5'b11100};
        for (int i = 0; i < 9; i++)
            one_op(ops[i], 1'b1, 64'hF000_0000_0000_0003, 64'h0123_4567_89AB_CDEF, "R3 R4 dbl");
        run_amo(mk(5'b00000, 3'b011), 64'h40, 64'h3, 64'h4, -1, 0, 0);
        chk(g_vaddr == 64'h40 && g_perm == 2'b11, "R2 translate addr/perm", g_vaddr, 64'h40);
    endtask

    task automatic t_ops_word;
        logic [4:0] ops [9] = '{5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                                5'b10000, 5'b10100, 5'b11000, 5'b11100};
        for (int i = 0; i < 9; i++)
            one_op(ops[i], 1'b0, 64'h1234_5678_7FFF_FFF0, 64'hAAAA_BBBB_8000_0010, "R5 R3 word");
    endtask

    task automatic t_minmax_edges;
        one_op(5'b10000, 1'b1, 64'h8000_0000_0000_0000, 64'h1, "R4 smin dbl");
        one_op(5'b11000, 1'b1, 64'h8000_0000_0000_0000, 64'h1, "R4 umin dbl");
        one_op(5'b10100, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, "R4 smax word");
        one_op(5'b11100, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, "R4 umax word");
        one_op(5'b00000, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R5 add wrap word");
    endtask

    task automatic t_illegal;
        logic [31:0] bad [3];
        bad[0] = mk(5'b00010, 3'b010);
        bad[1] = mk(5'b00000, 3'b000);
        bad[2] = {mk(5'b00000, 3'b011)} ^ 32'h1;
        for (int i = 0; i < 3; i++) begin
            run_amo(bad[i], 64'hDEAD_0000 + 64'(i), 64'h1, 64'h2, -1, 0, 0);
            chk(g_fault && g_cause == 3'd0, "R1 illegal cause", {61'b0, g_cause}, 64'h0);
            chk(g_faddr == 64'hDEAD_0000 + 64'(i), "R1 illegal addr", g_faddr, 64'hDEAD_0000 + 64'(i));
            chk(!g_any_port, "R1 no port activity", {63'b0, g_any_port}, 64'h0);
        end
    endtask

    task automatic t_xlate_fault;
        logic [63:0] prev;
        prev = rd_value;
        run_amo(mk(5'b00000, 3'b011), 64'h7700, 64'h1, 64'h2, 0, 0, 0);
        chk(g_fault && g_cause == 3'd1, "R7 cause", {61'b0, g_cause}, 64'h1);
        chk(g_faddr == 64'h7700, "R7 virtual addr", g_faddr, 64'h7700);
        chk(g_steps == 1 && g_old == prev, "R7 stop/rd kept", g_old, prev);
    endtask

    task automatic t_mem_faults;
        for (int s = 1; s <= 3; s++) begin
            logic [63:0] prev;
            prev = rd_value;
            run_amo(mk(5'b01000, 3'b010), 64'h9900, 64'h1, 64'h2, s, 0, 0);
            chk(g_fault && int'(g_cause) == s + 1, "R8 cause", {61'b0, g_cause}, 64'(s + 1));
            chk(g_faddr == (64'h9900 ^ XOFF), "R8 translated addr", g_faddr, 64'h9900 ^ XOFF);
            chk(g_steps == s + 1 && g_order_ok, "R8 no later step", 64'(g_steps), 64'(s + 1));
            chk(g_old == prev, "R8 rd kept", g_old, prev);
        end
    endtask

    task automatic t_busy_ignore;
        run_amo(mk(5'b00100, 3'b011), 64'h2000, 64'hFF00, 64'h0F0F, -1, 2, 1);
        chk(g_done && g_wdata == 64'hF00F, "R9 poke ignored wdata", g_wdata, 64'hF00F);
        chk(g_old == 64'h0F0F && g_vaddr == 64'h2000, "R9 poke ignored addr", g_vaddr, 64'h2000);
        chk(g_busy_ok && g_pulse_ok && g_order_ok, "R9 busy/pulse with waits", {63'b0, g_busy_ok}, 64'h1);
        repeat (3) @(negedge clk);
        chk(!busy && !xl_req, "R9 no late accept", {63'b0, busy}, 64'h0);
    endtask

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_ops_double;
        t_ops_word;
        t_minmax_edges;
        t_illegal;
        t_xlate_fault;
        t_mem_faults;
        t_busy_ignore;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule